// File: doc/BRIEF.md
# SD DAT0 Busy Detector with Timeout

This block sits beside the command and data path of an SD/MMC host and watches the card's DAT0 line after a command whose response announces a busy phase. DAT0 passes through a flop synchroniser first. The block then shows the live busy level as a status bit. When the line is released after a busy response, it records the end of busy in a sticky flag. While the busy wait is open, a loadable down-counter limits how long the wait may last.

Software computes the timer load as the busy time in milliseconds times the card clock frequency, divided by 1000. When the command gives no busy time, it uses 1000 ms. The package function `busy_ticks` performs that conversion. A load of zero disables the limit. The busy-end flag and the timeout flag are cleared by writing ones. Either flag can raise the interrupt line, subject to a mask.

Top module: `sd_busy_watch`

## Requirements
- R1: Status bit 20 equals the inverse of DAT0 after a two-flop synchroniser. Bit 20 never raises `irq`, even when mask bit 20 is set.
- R2: Status bit 21 (busy end) is set only when the synchronised DAT0 returns high after it was seen low during the wait that a busy response opened.
- R3: Bit 21 stays set until a clear write with bit 21 set. A clear write to other bits leaves it set.
- R4: `irq` is high exactly when (bit 21 and mask bit 21) or (bit 3 and mask bit 3) holds.
- R5: If the synchronised DAT0 is not seen low within 8 card clocks after a busy response, the block treats the command as having no busy phase. It then sets no busy-end flag, stops the timer and raises no timeout.
- R6: Busy that starts a few clocks after the response, but inside the 8-clock window, is still tracked to its end.
- R7: A timer loaded with N, N>0, counts down once per clock while a busy wait is open. When it reaches zero, status bit 3 (data timeout) is set N clocks after the response, the wait closes and no busy-end flag follows.
- R8: A timer loaded with 0 never raises a timeout. A busy wait then lasts until DAT0 is released.
- R9: A command error given with the response prevents the wait from opening. A command error during the wait closes it at once. In both cases no busy-end flag is set.
- R10: A response strobe without the busy-expected qualifier opens no wait.
- R11: Bit 3 is sticky and is cleared by a clear write with bit 3 set.
- R12: A load of busy_ticks(0 ms, f) = 1000·f/1000 times out after exactly that many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat0_in | input | 1 | Raw DAT0 level from the card |
| rsp_done | input | 1 | One-cycle strobe at the end of a command response |
| rsp_busy | input | 1 | Qualifier: the response carries a busy phase |
| cmd_err | input | 1 | Command CRC failure or command timeout |
| tmr_wr | input | 1 | Load strobe for the data timer |
| tmr_wdata | input | TMR_W | Timer load value in card clocks |
| clr_wr | input | 1 | Clear-write strobe |
| clr_data | input | STAT_W | Write-one-to-clear bits |
| irq_mask | input | STAT_W | Interrupt enable per status bit |
| status | output | STAT_W | Bit 20 live busy, bit 21 busy end, bit 3 data timeout |
| irq | output | 1 | Masked interrupt request |

## Verification
The tracking state and the timer cannot be seen directly, so each fault appears only through the three status bits and `irq`. A tracker stuck in the wait, or one that closes the probe window early, shows as a missing or extra busy-end flag within a few clocks after DAT0 returns high. A timer that is off by one moves the timeout bit by one clock, and the reference model, which is compared on every clock, catches that at once. A timer that keeps running after the wait has closed shows as a late timeout during a command with no busy phase.

// File: rtl/sdb_pkg.sv
`timescale 1ns/1ps
package sdb_pkg;
  localparam int BIT_TMO  = 3;
  localparam int BIT_LIVE = 20;
  localparam int BIT_END  = 21;
  localparam int unsigned DEFAULT_BUSY_MS = 1000;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_PROBE = 2'd1, PH_BUSY = 2'd2} phase_e;

  // Busy duration in ms to card clocks; 0 ms means "not given".
  function automatic longint unsigned busy_ticks(input int unsigned ms,
                                                 input longint unsigned clk_hz);
    longint unsigned t;
    t = (ms == 0) ? longint'(DEFAULT_BUSY_MS) : longint'(ms);
    return (t * clk_hz) / 1000;
  endfunction
endpackage

// File: rtl/sdb_sync.sv
`timescale 1ns/1ps
module sdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic line_prev
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign line      = chain[STAGES-1];
  assign line_prev = chain[STAGES];
endmodule

// File: rtl/sdb_timer.sv
`timescale 1ns/1ps
module sdb_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] ld_val,
  input  logic          run,
  output logic [TW-1:0] count,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  assign expire = run && !load && (cnt_q == TW'(1));
  assign count  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= ld_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
  end
endmodule

// File: rtl/sdb_track.sv
`timescale 1ns/1ps
module sdb_track
  import sdb_pkg::*;
#(
  parameter int WIN = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line,
  input  logic   line_prev,
  input  logic   rsp_done,
  input  logic   rsp_busy,
  input  logic   cmd_err,
  input  logic   expire,
  output phase_e phase,
  output logic   run,
  output logic   end_evt
);
  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;

  phase_e         ph_q, ph_n;
  logic [WCW-1:0] wc_q, wc_n;
  logic           release_edge;

  assign release_edge = line && !line_prev;

  always_comb begin
    ph_n    = ph_q;
    wc_n    = wc_q;
    end_evt = 1'b0;
    case (ph_q)
      PH_IDLE: if (rsp_done && rsp_busy && !cmd_err) begin
        ph_n = PH_PROBE;
        wc_n = '0;
      end
      PH_PROBE: begin
        if (cmd_err || expire)           ph_n = PH_IDLE;
        else if (!line)                  ph_n = PH_BUSY;
        else if (wc_q == WCW'(WIN - 1))  ph_n = PH_IDLE;
        else                             wc_n = wc_q + WCW'(1);
      end
      PH_BUSY: begin
        if (cmd_err || expire) ph_n = PH_IDLE;
        else if (release_edge) begin
          end_evt = 1'b1;
          ph_n    = PH_IDLE;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      wc_q <= '0;
    end else begin
      ph_q <= ph_n;
      wc_q <= wc_n;
    end
  end

  assign phase = ph_q;
  assign run   = (ph_q != PH_IDLE);
endmodule

// File: rtl/sd_busy_watch.sv
`timescale 1ns/1ps
module sd_busy_watch
  import sdb_pkg::*;
#(
  parameter int TMR_W       = 32,
  parameter int STAT_W      = 32,
  parameter int PROBE_WIN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat0_in,
  input  logic              rsp_done,
  input  logic              rsp_busy,
  input  logic              cmd_err,
  input  logic              tmr_wr,
  input  logic [TMR_W-1:0]  tmr_wdata,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam logic [STAT_W-1:0] IRQ_SRC =
    (STAT_W'(1) << BIT_END) | (STAT_W'(1) << BIT_TMO);

  // named internal events, visible to the bound checker
  logic             line, line_prev;
  logic             run, end_evt, tmo_evt;
  logic [TMR_W-1:0] tmr_cnt;
  phase_e           phase;
  logic             end_q, tmo_q;

  sdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(dat0_in),
    .line(line), .line_prev(line_prev)
  );

  sdb_timer #(.TW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_wr), .ld_val(tmr_wdata),
    .run(run), .count(tmr_cnt), .expire(tmo_evt)
  );

  sdb_track #(.WIN(PROBE_WIN)) u_trk (
    .clk(clk), .rst_n(rst_n), .line(line), .line_prev(line_prev),
    .rsp_done(rsp_done), .rsp_busy(rsp_busy), .cmd_err(cmd_err),
    .expire(tmo_evt), .phase(phase), .run(run), .end_evt(end_evt)
  );

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      end_q <= end_evt || (end_q && !(clr_wr && clr_data[BIT_END]));
      tmo_q <= tmo_evt || (tmo_q && !(clr_wr && clr_data[BIT_TMO]));
    end
  end

  always_comb begin
    status           = '0;
    status[BIT_LIVE] = !line;
    status[BIT_END]  = end_q;
    status[BIT_TMO]  = tmo_q;
  end

  assign irq = |(status & irq_mask & IRQ_SRC);
endmodule

// File: rtl/sdb_chk.sv
`timescale 1ns/1ps
module sdb_chk
  import sdb_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int TMR_W  = 32,
  parameter int WIN    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] status,
  input logic              irq,
  input logic              clr_wr,
  input logic [STAT_W-1:0] clr_data,
  input logic              cmd_err,
  input logic              tmr_wr,
  input phase_e            phase,
  input logic              tmo_evt,
  input logic [TMR_W-1:0]  tmr_cnt
);
  int unsigned probe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 probe_run <= 0;
    else if (phase == PH_PROBE) probe_run <= probe_run + 1;
    else                        probe_run <= 0;
  end

  // R1
  live_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_LIVE] && !status[BIT_END] && !status[BIT_TMO]) |-> !irq);

  // R4
  no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[BIT_END] && !status[BIT_TMO]) |-> !irq);

  // R2
  end_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[BIT_END]) |-> ($past(phase) == PH_BUSY));

  // R3
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_END] && !(clr_wr && clr_data[BIT_END])) |=> status[BIT_END]);

  // R11
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_TMO] && !(clr_wr && clr_data[BIT_TMO])) |=> status[BIT_TMO]);

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && cmd_err) |=> (phase == PH_IDLE));

  // R7
  tmo_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (phase == PH_IDLE && status[BIT_TMO]));

  // R8
  zero_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt == '0 && !tmr_wr && !status[BIT_TMO]) |=> !status[BIT_TMO]);

  // R5
  probe_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROBE) |-> (probe_run < WIN));
endmodule

bind sd_busy_watch sdb_chk #(.STAT_W(STAT_W), .TMR_W(TMR_W), .WIN(PROBE_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .irq(irq),
  .clr_wr(clr_wr), .clr_data(clr_data), .cmd_err(cmd_err), .tmr_wr(tmr_wr),
  .phase(phase), .tmo_evt(tmo_evt), .tmr_cnt(tmr_cnt)
);

// File: tb/tb_sd_busy_watch.sv
`timescale 1ns/1ps
module tb_sd_busy_watch;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dat0_in = 1'b1;
  logic        rsp_done = 1'b0, rsp_busy = 1'b0, cmd_err = 1'b0;
  logic        tmr_wr = 1'b0;
  logic [31:0] tmr_wdata = '0;
  logic        clr_wr = 1'b0;
  logic [31:0] clr_data = '0;
  logic [31:0] irq_mask = '0;
  logic [31:0] status;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  sd_busy_watch dut (
    .clk(clk), .rst_n(rst_n), .dat0_in(dat0_in), .rsp_done(rsp_done),
    .rsp_busy(rsp_busy), .cmd_err(cmd_err), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .clr_wr(clr_wr), .clr_data(clr_data),
    .irq_mask(irq_mask), .status(status), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit      line_q[$];   // [0] = level seen by the tracker now, [1] = one clock younger
  int      mode;        // 0 none, 1 looking for busy, 2 inside busy
  int      looked;
  longint  left;
  bit      m_end, m_tmo, m_seen_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      line_q = '{1'b1, 1'b1};
      mode = 0; looked = 0; left = 0; m_end = 0; m_tmo = 0; m_seen_rst = 1;
    end else begin
      bit seen, hit_zero, rel;
      seen = line_q[0];
      hit_zero = (mode != 0) && !tmr_wr && (left == 1);
      rel = 0;
      if (tmr_wr) left = tmr_wdata;
      else if (mode != 0 && left > 0) left = left - 1;
      if (mode == 0) begin
        if (rsp_done && rsp_busy && !cmd_err) begin mode = 1; looked = 0; end
      end else if (cmd_err || hit_zero) begin
        mode = 0;
      end else if (mode == 1) begin
        if (!seen) mode = 2;
        else if (looked == WIN - 1) mode = 0;
        else looked++;
      end else if (seen) begin
        rel = 1; mode = 0;
      end
      m_end = rel || (m_end && !(clr_wr && clr_data[21]));
      m_tmo = hit_zero || (m_tmo && !(clr_wr && clr_data[3]));
      void'(line_q.pop_front());
      line_q.push_back(dat0_in);
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && m_seen_rst && !done) begin
      chk("R1 live busy bit", 32'(status[20]), 32'(!line_q[0]));
      chk("R2 busy-end bit", 32'(status[21]), 32'(m_end));
      chk("R7 timeout bit", 32'(status[3]), 32'(m_tmo));
      chk("R4 irq", 32'(irq), 32'((m_end && irq_mask[21]) || (m_tmo && irq_mask[3])));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resp(input bit busy, input bit err);
    @(negedge clk); rsp_done = 1; rsp_busy = busy; cmd_err = err;
    @(negedge clk); rsp_done = 0; rsp_busy = 0; cmd_err = 0;
  endtask

  task automatic load_tmr(input logic [31:0] v);
    @(negedge clk); tmr_wr = 1; tmr_wdata = v;
    @(negedge clk); tmr_wr = 0;
  endtask

  task automatic clear(input logic [31:0] v);
    @(negedge clk); clr_wr = 1; clr_data = v;
    @(negedge clk); clr_wr = 0; clr_data = '0;
  endtask

  task automatic finish_up;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    longint ticks;
    cyc(4); rst_n = 1; cyc(2);
    chk("R1 reset status", status, 32'h0);
    chk("R4 reset irq", 32'(irq), 32'h0);

    // R1: live level, no interrupt from it
    irq_mask = 32'h0010_0000;
    dat0_in = 0; cyc(4);
    chk("R1 live set", 32'(status[20]), 32'h1);
    chk("R1 no irq from live", 32'(irq), 32'h0);
    dat0_in = 1; cyc(4);
    chk("R2 no end without response", 32'(status[21]), 32'h0);

    // R2/R4: ordinary busy phase
    irq_mask = '0;
    load_tmr(1000);
    resp(1, 0); dat0_in = 0; cyc(20); dat0_in = 1; cyc(5);
    chk("R2 end flagged", 32'(status[21]), 32'h1);
    chk("R4 masked end no irq", 32'(irq), 32'h0);
    irq_mask = 32'h0020_0000; cyc(1);
    chk("R4 unmasked end irq", 32'(irq), 32'h1);

    // R3: sticky, wrong clear bit ignored
    cyc(10);
    chk("R3 end held", 32'(status[21]), 32'h1);
    clear(32'h0000_0008); cyc(1);
    chk("R3 other clear ignored", 32'(status[21]), 32'h1);
    clear(32'h0020_0000); cyc(1);
    chk("R3 cleared", 32'(status[21]), 32'h0);
    chk("R4 irq drops", 32'(irq), 32'h0);

    // R6: busy starts late inside window
    load_tmr(1000);
    resp(1, 0); cyc(4); dat0_in = 0; cyc(10); dat0_in = 1; cyc(5);
    chk("R6 late busy end", 32'(status[21]), 32'h1);
    clear(32'h0020_0000);

    // R5: no busy within window, timer stopped
    load_tmr(12);
    resp(1, 0); cyc(20);
    chk("R5 no end flag", 32'(status[21]), 32'h0);
    chk("R5 timer stopped", 32'(status[3]), 32'h0);
    dat0_in = 0; cyc(5); dat0_in = 1; cyc(5);
    chk("R5 later pulse ignored", 32'(status[21]), 32'h0);

    // R7: timeout closes wait
    irq_mask = 32'h0000_0008;
    load_tmr(30);
    resp(1, 0); dat0_in = 0; cyc(25);
    chk("R7 not yet", 32'(status[3]), 32'h0);
    chk("R4 no irq yet", 32'(irq), 32'h0);
    cyc(10);
    chk("R7 timeout", 32'(status[3]), 32'h1);
    chk("R4 timeout irq", 32'(irq), 32'h1);
    dat0_in = 1; cyc(5);
    chk("R7 no end after timeout", 32'(status[21]), 32'h0);

    // R11
    clear(32'h0000_0008); cyc(1);
    chk("R11 timeout cleared", 32'(status[3]), 32'h0);

    // R8: zero load never times out
    load_tmr(0);
    resp(1, 0); dat0_in = 0; cyc(80);
    chk("R8 no timeout", 32'(status[3]), 32'h0);
    dat0_in = 1; cyc(5);
    chk("R8 end flagged", 32'(status[21]), 32'h1);
    clear(32'h0020_0000);

    // R9: error with response, and error during busy
    resp(1, 1); dat0_in = 0; cyc(6); dat0_in = 1; cyc(5);
    chk("R9 error at response", 32'(status[21]), 32'h0);
    resp(1, 0); dat0_in = 0; cyc(6);
    @(negedge clk); cmd_err = 1; @(negedge clk); cmd_err = 0;
    cyc(3); dat0_in = 1; cyc(5);
    chk("R9 error during busy", 32'(status[21]), 32'h0);

    // R10: response without busy qualifier
    resp(0, 0); dat0_in = 0; cyc(6); dat0_in = 1; cyc(5);
    chk("R10 no busy expected", 32'(status[21]), 32'h0);

    // R12: default 1000 ms at a notional 50 kHz card clock
    ticks = (64'd1000 * 64'd50000) / 64'd1000;
    chk("R12 conversion", 32'(sdb_pkg::busy_ticks(0, 64'd50000)), 32'(ticks));
    load_tmr(32'(ticks));
    resp(1, 0); dat0_in = 0;
    cyc(int'(ticks) - 10);
    chk("R12 before limit", 32'(status[3]), 32'h0);
    cyc(20);
    chk("R12 after limit", 32'(status[3]), 32'h1);
    dat0_in = 1; cyc(4);
    finish_up();
  end
endmodule